// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block keeps time for a processor subsystem. A 64-bit time base counts up by one on every system clock and is read and written as two 32-bit halves. Next to it sits a 32-bit down-counter that measures a delay chosen by software. When the delay runs out, a status flag is raised. If the interrupt enable is on, that flag drives an interrupt request. If automatic reload is on, the counter restarts from a separately held reload value.

Software reaches the block through a single-cycle register port made of an address, a write strobe, write data, combinational read data and a privilege flag. The time base only accepts writes that are marked privileged; any access level may read it. The status register is cleared by writing ones to it. Its upper bits are kept as placeholders for interval-timer and watchdog-reset indications and have no source in this block.

Top module: `tbdec_timer`

## Requirements
- R1: After reset, the 64-bit time base rises by exactly one on every clock; its low half reads at address 0 and its high half at address 1.
- R2: When the low half holds all ones, the same clock edge wraps it to zero and adds one to the high half.
- R3: A write to address 0 or 1 with `acc_super` low is ignored: the time base keeps counting as if no write had happened.
- R4: A privileged write to one time-base half loads that half with the write data. The other half carries on counting in that clock, and a carry from a written low half is never propagated.
- R5: The delay counter (address 2, written directly) falls by one per clock while it is nonzero. It stays at zero when automatic reload is off.
- R6: A clock edge on which the delay counter steps from 1 to 0 sets status bit 0 (address 5). Loading zero by software does not set it.
- R7: When control bit 1 (address 4) is set, the clock after an expiry loads the counter from the reload register (address 3). A counter zeroed by software is not reloaded.
- R8: `dec_irq` is high exactly when status bit 0 and control bit 0 are both set.
- R9: Writing a 1 to a status bit clears it and writing a 0 leaves it alone. An expiry on the same edge as a clear leaves bit 0 set.
- R10: Reset clears the time base, delay counter, reload value, control and status, and `dec_irq` is low. Status bits 3:1 and unmapped addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both counters advance on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | Access is a write (1) or read (0) |
| acc_super | input | 1 | Access carries privileged level |
| acc_addr | input | 3 | Register word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr`, combinational |
| dec_irq | output | 1 | Delay-counter interrupt request |
| tmr_status | output | 4 | Status flags; bit 0 is delay expiry |

## Verification
Two kinds of collision can land on one clock edge. The first is an expiry of the delay counter on the same edge as a software write-one clear of its status flag. The bench provokes it by loading the counter with 3, waiting two clocks and then issuing the clear so that it is sampled on the expiry edge; it then judges that the flag reads set, and that a later clear alone does remove it. The second is a time-base half being written on the same edge that the other half counts or would carry. The bench writes the high half and then a near-wrap low value on consecutive edges and tracks both halves through the wrap.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_TB_LO  = 3'd0,
    RA_TB_HI  = 3'd1,
    RA_DEC    = 3'd2,
    RA_RELOAD = 3'd3,
    RA_CTRL   = 3'd4,
    RA_STAT   = 3'd5
  } reg_addr_e;

  // control and status bit positions
  localparam int CTRL_IRQ_EN    = 0;
  localparam int CTRL_RELOAD_EN = 1;
  localparam int STAT_DEC       = 0;

  // 64-bit style step of a split counter, kept as arithmetic for reuse
  function automatic logic [2*REG_W-1:0] split_step(
    input logic [REG_W-1:0] hi,
    input logic [REG_W-1:0] lo
  );
    return {hi, lo} + (2*REG_W)'(1);
  endfunction

endpackage

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] tb_lo,
  output logic [HALF_W-1:0] tb_hi,
  output logic              lo_carry
);

  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_next;
  logic [HALF_W-1:0] hi_next;
  logic [FULL_W-1:0] tb_full;

  assign tb_full  = {tb_hi, tb_lo};
  assign lo_carry = &tb_lo;

  always_comb begin
    lo_next = wr_lo ? wdata : tb_lo + HALF_W'(1);
    hi_next = wr_hi ? wdata : tb_hi + HALF_W'(lo_carry && !wr_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_lo <= '0;
      tb_hi <= '0;
    end else begin
      tb_lo <= lo_next;
      tb_hi <= hi_next;
    end
  end

  assert_tb_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> tb_full == $past(tb_full) + FULL_W'(1));

  assert_tb_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_carry && !wr_lo && !wr_hi) |=> (tb_lo == '0) && (tb_hi == $past(tb_hi) + HALF_W'(1)));

  assert_lo_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (tb_lo == $past(wdata)) && (tb_hi == $past(tb_hi)));

  assert_hi_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (tb_hi == $past(wdata)) && (tb_lo == $past(tb_lo) + HALF_W'(1)));

endmodule

// File: rtl/tbdec_decrementer.sv
module tbdec_decrementer #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dec,
  input  logic              wr_reload,
  input  logic [HALF_W-1:0] wdata,
  input  logic              reload_en,
  output logic [HALF_W-1:0] dec_val,
  output logic [HALF_W-1:0] reload_val,
  output logic              expire_evt
);

  logic expired_q;
  logic reload_due;
  logic running;

  assign running    = (dec_val != '0);
  assign expire_evt = (dec_val == HALF_W'(1)) && !wr_dec;
  assign reload_due = expired_q && reload_en && !wr_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_val    <= '0;
      reload_val <= '0;
      expired_q  <= 1'b0;
    end else begin
      expired_q <= expire_evt;
      if (wr_reload) reload_val <= wdata;
      if (wr_dec)          dec_val <= wdata;
      else if (reload_due) dec_val <= reload_val;
      else if (running)    dec_val <= dec_val - HALF_W'(1);
    end
  end

  assert_dec_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dec && dec_val != '0) |=> dec_val == $past(dec_val) - HALF_W'(1));

  assert_dec_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dec && dec_val == '0 && !expired_q) |=> dec_val == '0);

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && reload_en && !wr_dec) |=> dec_val == $past(reload_val));

endmodule

// File: rtl/tbdec_ctlstat.sv
module tbdec_ctlstat #(
  parameter int CTRL_W = 2,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              set_dec,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  import tbdec_pkg::*;

  logic [STAT_W-1:0] clr_vec;
  assign clr_vec = wr_stat ? stat_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_wdata;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == STAT_DEC) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[i] <= 1'b0;
        else        stat_q[i] <= set_dec | (stat_q[i] & ~clr_vec[i]);
      end
    end else begin : g_hold
      // placeholder flag with no event source
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[i] <= 1'b0;
        else        stat_q[i] <= stat_q[i] & ~clr_vec[i];
      end
    end
  end

  assign irq = stat_q[STAT_DEC] & ctrl_q[CTRL_IRQ_EN];

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_dec |=> stat_q[STAT_DEC]);

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && stat_wdata[STAT_DEC] && !set_dec) |=> !stat_q[STAT_DEC]);

  assert_w0_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[STAT_DEC] && !(wr_stat && stat_wdata[STAT_DEC])) |=> stat_q[STAT_DEC]);

  assert_no_stray_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[STAT_DEC] && !set_dec) |=> !stat_q[STAT_DEC]);

endmodule

// File: rtl/tbdec_timer.sv
module tbdec_timer #(
  parameter int HALF_W = 32,
  parameter int ADDR_W = 3,
  parameter int CTRL_W = 2,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_super,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [HALF_W-1:0] acc_wdata,
  output logic [HALF_W-1:0] acc_rdata,
  output logic              dec_irq,
  output logic [STAT_W-1:0] tmr_status
);
  import tbdec_pkg::*;

  logic              wr_hit;
  logic              wr_tb_lo, wr_tb_hi, wr_dec, wr_reload, wr_ctrl, wr_stat;
  logic [HALF_W-1:0] tb_lo, tb_hi, dec_val, reload_val;
  logic              lo_carry, expire_evt;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q;
  reg_addr_e         addr_e;

  assign addr_e    = reg_addr_e'(acc_addr);
  assign wr_hit    = acc_valid && acc_write;
  assign wr_tb_lo  = wr_hit && acc_super && (addr_e == RA_TB_LO);
  assign wr_tb_hi  = wr_hit && acc_super && (addr_e == RA_TB_HI);
  assign wr_dec    = wr_hit && (addr_e == RA_DEC);
  assign wr_reload = wr_hit && (addr_e == RA_RELOAD);
  assign wr_ctrl   = wr_hit && (addr_e == RA_CTRL);
  assign wr_stat   = wr_hit && (addr_e == RA_STAT);

  tbdec_timebase #(.HALF_W(HALF_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_tb_lo), .wr_hi(wr_tb_hi),
    .wdata(acc_wdata), .tb_lo(tb_lo), .tb_hi(tb_hi), .lo_carry(lo_carry)
  );

  tbdec_decrementer #(.HALF_W(HALF_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_dec(wr_dec), .wr_reload(wr_reload),
    .wdata(acc_wdata), .reload_en(ctrl_q[CTRL_RELOAD_EN]),
    .dec_val(dec_val), .reload_val(reload_val), .expire_evt(expire_evt)
  );

  tbdec_ctlstat #(.CTRL_W(CTRL_W), .STAT_W(STAT_W)) u_cs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .ctrl_wdata(acc_wdata[CTRL_W-1:0]), .stat_wdata(acc_wdata[STAT_W-1:0]),
    .set_dec(expire_evt), .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(dec_irq)
  );

  always_comb begin
    case (addr_e)
      RA_TB_LO:  acc_rdata = tb_lo;
      RA_TB_HI:  acc_rdata = tb_hi;
      RA_DEC:    acc_rdata = dec_val;
      RA_RELOAD: acc_rdata = reload_val;
      RA_CTRL:   acc_rdata = HALF_W'(ctrl_q);
      RA_STAT:   acc_rdata = HALF_W'(stat_q);
      default:   acc_rdata = '0;
    endcase
  end

  assign tmr_status = stat_q;

  // unprivileged writes to either half leave the count running
  assert_user_tb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !acc_super && (addr_e == RA_TB_LO || addr_e == RA_TB_HI))
      |=> ({tb_hi, tb_lo} == $past(split_step(tb_hi, tb_lo))));

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTRL_IRQ_EN] |-> !dec_irq);

endmodule

// File: tb/test_tbdec_timer.sv
`timescale 1ns/100ps
module test_tbdec_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_super = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        dec_irq;
  logic [3:0]  tmr_status;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbdec_timer i_tbdec_timer (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_super(acc_super), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .dec_irq(dec_irq), .tmr_status(tmr_status)
  );

  // start, cycles waited, expected counter, expected status bit 0
  localparam logic [31:0] VEC [6][4] = '{
    '{32'd10,  32'd4,  32'd6,  32'd0},
    '{32'd5,   32'd5,  32'd0,  32'd1},
    '{32'd2,   32'd7,  32'd0,  32'd1},
    '{32'd1,   32'd1,  32'd0,  32'd1},
    '{32'd100, 32'd50, 32'd50, 32'd0},
    '{32'd0,   32'd3,  32'd0,  32'd0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; the write is sampled on the next posedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic sup);
    acc_valid = 1'b1; acc_write = 1'b1; acc_super = sup;
    acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_super = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    acc_addr = a;
    #0.2;
    d = acc_rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, h;
    // R10 reset state
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R10", "tb lo in reset", v, 32'd0);
    rd(3'd2, v); chk("R10", "dec in reset", v, 32'd0);
    chk("R10", "status in reset", {28'd0, tmr_status}, 32'd0);
    chk("R10", "irq in reset", {31'd0, dec_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 one step per clock
    rd(3'd0, v); @(negedge clk); rd(3'd0, v2);
    chk("R1", "tb lo step", v2, v + 32'd1);

    // R4 high write, low keeps counting; then low write near wrap
    rd(3'd0, v);
    wr(3'd1, 32'd5, 1'b1);
    rd(3'd1, h);  chk("R4", "hi loaded", h, 32'd5);
    rd(3'd0, v2); chk("R4", "lo counts during hi write", v2, v + 32'd1);
    wr(3'd0, 32'hFFFF_FFFE, 1'b1);
    rd(3'd0, v); chk("R4", "lo loaded", v, 32'hFFFF_FFFE);
    rd(3'd1, h); chk("R4", "hi held on lo write", h, 32'd5);
    @(negedge clk);
    rd(3'd0, v); chk("R2", "lo all ones", v, 32'hFFFF_FFFF);
    rd(3'd1, h); chk("R2", "hi before carry", h, 32'd5);
    @(negedge clk);
    rd(3'd0, v); chk("R2", "lo wrapped", v, 32'd0);
    rd(3'd1, h); chk("R2", "hi carried", h, 32'd6);

    // R3 unprivileged writes ignored
    rd(3'd0, v);
    wr(3'd0, 32'h0000_0123, 1'b0);
    rd(3'd0, v2); chk("R3", "user lo write ignored", v2, v + 32'd1);
    wr(3'd1, 32'hABCD_0000, 1'b0);
    rd(3'd1, h); chk("R3", "user hi write ignored", h, 32'd6);

    // R5 / R6 vector table
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, 32'd0, 1'b0);
      wr(3'd5, 32'hF, 1'b0);
      wr(3'd2, VEC[i][0], 1'b0);
      repeat (VEC[i][1]) @(negedge clk);
      rd(3'd2, v); chk("R5", $sformatf("row %0d counter", i), v, VEC[i][2]);
      chk("R6", $sformatf("row %0d expiry flag", i), {31'd0, tmr_status[0]}, VEC[i][3]);
    end

    // R7 / R8 auto-reload and interrupt
    wr(3'd3, 32'd4, 1'b0);
    wr(3'd4, 32'd3, 1'b0);
    wr(3'd2, 32'd0, 1'b0);
    wr(3'd5, 32'd1, 1'b0);
    wr(3'd2, 32'd2, 1'b0);
    rd(3'd2, v); chk("R5", "loaded 2", v, 32'd2);
    @(negedge clk); @(negedge clk);
    rd(3'd2, v); chk("R5", "reached zero", v, 32'd0);
    chk("R6", "flag on expiry", {31'd0, tmr_status[0]}, 32'd1);
    chk("R8", "irq enabled", {31'd0, dec_irq}, 32'd1);
    @(negedge clk);
    rd(3'd2, v); chk("R7", "reloaded", v, 32'd4);
    @(negedge clk);
    rd(3'd2, v); chk("R7", "counts after reload", v, 32'd3);
    wr(3'd2, 32'd0, 1'b0);
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R7", "software zero not reloaded", v, 32'd0);
    wr(3'd4, 32'd2, 1'b0);
    chk("R8", "irq masked", {31'd0, dec_irq}, 32'd0);
    wr(3'd4, 32'd0, 1'b0);

    // R9 expiry and clear on the same edge
    wr(3'd5, 32'd1, 1'b0);
    chk("R9", "flag cleared", {31'd0, tmr_status[0]}, 32'd0);
    wr(3'd2, 32'd3, 1'b0);
    @(negedge clk); @(negedge clk);
    wr(3'd5, 32'd1, 1'b0);
    chk("R9", "set wins over clear", {31'd0, tmr_status[0]}, 32'd1);
    chk("R8", "irq off with enable off", {31'd0, dec_irq}, 32'd0);
    wr(3'd5, 32'd0, 1'b0);
    chk("R9", "write zero keeps flag", {31'd0, tmr_status[0]}, 32'd1);
    wr(3'd5, 32'd1, 1'b0);
    chk("R9", "write one clears", {31'd0, tmr_status[0]}, 32'd0);

    // R10 placeholders and unmapped addresses
    chk("R10", "placeholder status", {29'd0, tmr_status[3:1]}, 32'd0);
    rd(3'd6, v); chk("R10", "addr 6 reads zero", v, 32'd0);
    rd(3'd7, v); chk("R10", "addr 7 reads zero", v, 32'd0);
    rd(3'd4, v); chk("R10", "ctrl readback", v, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule